// File: doc/BRIEF.md
# IO Fragment Bus Cycle Sequencer

This block sits behind a splitter that breaks a misaligned processor access into fragments. It takes one fragment aimed at IO space and turns it into 16-bit bus cycles. A fragment is a physical byte address, a length of one, two or three bytes, and a direction. A write carries right-aligned data. The block works out exactly which word reads, word writes and byte writes the fragment needs. It issues them one at a time on a request/acknowledge port and reports completion with a one-cycle done pulse.

Devices on the bus may have side effects on read, and a word read-modify-write is not the same as a byte write. So the block never adds a cycle, never widens a write, and never reads in order to write. Reads are always word reads. The block places the read result in a longword at the position an aligned read would deliver it, and the processor side picks out the bytes it needs. If a cycle is not acknowledged in time, the fragment is abandoned with an error flag and no further cycles are issued.

Top module: `uio_cycle_seq`

## Requirements
- R1: A read issues word reads only (`bus_we_o`=0, `bus_byte_o`=0). If length plus address bit 0 is at most 2, it issues one read at the address. Otherwise it issues two reads, at the address and then at the address + 2.
- R2: The read result appears on `rdata_o` with the done pulse. For a one-cycle read, the returned word sits in bits 31:16 when address bit 1 is set and in bits 15:0 otherwise, and the other half is zero. For a two-cycle read, the result is {second word, first word}.
- R3: A one-byte write is one byte-write cycle at the address, whatever the offset. Data bits 7:0 go on `bus_wdata_o[7:0]`, bits 15:8 are driven to zero, and data bits 23:8 are ignored.
- R4: A two-byte write at an even address is one word write of data 15:0. At an odd address it is two byte writes: data 7:0 at the address, then data 15:8 at the address + 1.
- R5: A three-byte write at an odd address is a byte write of data 7:0 at the address, then a word write of data 23:8 at the address + 1. At an even address it is a word write of data 15:0 at the address, then a byte write of data 23:16 at the address + 2.
- R6: One cycle is in flight at a time. `bus_req_o` stays high with the address, flags and data stable until `bus_ack_i` is sampled. The next cycle's request follows the acknowledge with no gap. `done_o` pulses for one cycle, in the cycle after the final acknowledge. No request is made between fragments.
- R7: If a cycle is not acknowledged within `TMO_CYC` cycles of request (16 by default), the request drops and `done_o` pulses with `err_o`=1. The remaining cycles are not issued. `err_o` holds until the next fragment is accepted, which clears it.
- R8: `start_i` is ignored while a fragment is in progress (`bus_req_o` high).
- R9: After reset, `bus_req_o`, `done_o`, `err_o` and `rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept a fragment when idle |
| addr_i | input | ADDR_W | Physical byte address of the fragment |
| len_i | input | 2 | Length in bytes: 1, 2 or 3 |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 24 | Right-aligned write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Fragment aborted on timeout |
| rdata_o | output | 32 | Positioned read longword |
| bus_req_o | output | 1 | Bus cycle request |
| bus_addr_o | output | ADDR_W | Bus cycle byte address |
| bus_wdata_o | output | 16 | Bus cycle write data |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_byte_o | output | 1 | Bus cycle is a byte write |
| bus_ack_i | input | 1 | Bus cycle acknowledge |
| bus_rdata_i | input | 16 | Bus read word, valid with acknowledge |

## Verification
The assertions check several rules on every cycle:
- a request stays stable until it is acknowledged or times out;
- a wait of `TMO_CYC` cycles ends in an error completion;
- reads never carry the byte flag, and byte writes keep the upper lane zero;
- done is a single-cycle pulse with the bus idle;
- no fragment acknowledges more than two cycles.

Other behaviour only the bench scenarios can show. This covers the exact cycle list for each offset and length, byte order and data slicing, the placement of the read word, and that a late start is ignored. It also covers the aborted fragments that stop after zero or one cycles and the clearing of the error by the next fragment.

// File: rtl/uio_cycle_pkg.sv
package uio_cycle_pkg;
  localparam int unsigned SLOTS = 2;

  // one planned bus cycle, address given as offset from fragment base
  typedef struct packed {
    logic [1:0]  aoff;
    logic        we;
    logic        byt;
    logic [15:0] wd;
  } slot_t;
endpackage

// File: rtl/uio_cycle_plan.sv
module uio_cycle_plan
  import uio_cycle_pkg::*;
(
  input  logic                    wr_i,
  input  logic [1:0]              len_i,
  input  logic [1:0]              alo_i,
  input  logic [23:0]             wdata_i,
  output logic                    two_o,
  output slot_t [SLOTS-1:0]       slot_o
);
  always_comb begin
    two_o  = 1'b0;
    slot_o = '0;
    if (!wr_i) begin
      two_o          = ({1'b0, len_i} + {2'b00, alo_i[0]}) > 3'd2;
      slot_o[1].aoff = 2'd2;
    end else begin
      case (len_i)
        2'd2: begin
          if (alo_i[0]) begin
            two_o     = 1'b1;
            slot_o[0] = '{aoff: 2'd0, we: 1'b1, byt: 1'b1, wd: {8'h00, wdata_i[7:0]}};
            slot_o[1] = '{aoff: 2'd1, we: 1'b1, byt: 1'b1, wd: {8'h00, wdata_i[15:8]}};
          end else begin
            slot_o[0] = '{aoff: 2'd0, we: 1'b1, byt: 1'b0, wd: wdata_i[15:0]};
          end
        end
        2'd3: begin
          two_o = 1'b1;
          if (alo_i[0]) begin
            slot_o[0] = '{aoff: 2'd0, we: 1'b1, byt: 1'b1, wd: {8'h00, wdata_i[7:0]}};
            slot_o[1] = '{aoff: 2'd1, we: 1'b1, byt: 1'b0, wd: wdata_i[23:8]};
          end else begin
            slot_o[0] = '{aoff: 2'd0, we: 1'b1, byt: 1'b0, wd: wdata_i[15:0]};
            slot_o[1] = '{aoff: 2'd2, we: 1'b1, byt: 1'b1, wd: {8'h00, wdata_i[23:16]}};
          end
        end
        default: begin
          slot_o[0] = '{aoff: 2'd0, we: 1'b1, byt: 1'b1, wd: {8'h00, wdata_i[7:0]}};
        end
      endcase
    end
  end
endmodule

// File: rtl/uio_cycle_timer.sv
module uio_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/uio_read_pack.sv
module uio_read_pack (
  input  logic        two_i,
  input  logic        hi_i,
  input  logic [15:0] first_i,
  input  logic [15:0] last_i,
  output logic [31:0] data_o
);
  always_comb begin
    if (two_i)     data_o = {last_i, first_i};
    else if (hi_i) data_o = {last_i, 16'h0000};
    else           data_o = {16'h0000, last_i};
  end
endmodule

// File: rtl/uio_cycle_seq.sv
module uio_cycle_seq
  import uio_cycle_pkg::*;
#(
  parameter int unsigned ADDR_W  = 22,
  parameter int unsigned TMO_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        len_i,
  input  logic              wr_i,
  input  logic [23:0]       wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_byte_o,
  input  logic              bus_ack_i,
  input  logic [15:0]       bus_rdata_i
);
  logic              two_d;
  slot_t [SLOTS-1:0] slot_d;

  logic              busy_q, done_q, err_q, two_q, hi_q, wr_q, idx_q;
  logic [ADDR_W-1:0] base_q;
  slot_t [SLOTS-1:0] slot_q;
  logic [15:0]       w0_q;
  logic [31:0]       rdata_q;
  logic [31:0]       pack_w;
  logic              expire_w, accept_w, last_w;
  slot_t             cur_w;

  uio_cycle_plan u_plan (
    .wr_i    (wr_i),
    .len_i   (len_i),
    .alo_i   (addr_i[1:0]),
    .wdata_i (wdata_i),
    .two_o   (two_d),
    .slot_o  (slot_d)
  );

  assign accept_w = start_i && !busy_q;

  uio_cycle_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept_w || bus_ack_i),
    .run_i    (busy_q && !bus_ack_i),
    .expire_o (expire_w)
  );

  uio_read_pack u_pack (
    .two_i   (two_q),
    .hi_i    (hi_q),
    .first_i (w0_q),
    .last_i  (bus_rdata_i),
    .data_o  (pack_w)
  );

  assign cur_w  = slot_q[idx_q];
  assign last_w = (idx_q == two_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      two_q   <= 1'b0;
      hi_q    <= 1'b0;
      wr_q    <= 1'b0;
      idx_q   <= 1'b0;
      base_q  <= '0;
      slot_q  <= '0;
      w0_q    <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        base_q <= addr_i;
        slot_q <= slot_d;
        two_q  <= two_d;
        hi_q   <= addr_i[1];
        wr_q   <= wr_i;
        idx_q  <= 1'b0;
      end else if (busy_q && bus_ack_i) begin
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (!wr_q) rdata_q <= pack_w;
        end else begin
          idx_q <= 1'b1;
          w0_q  <= bus_rdata_i;
        end
      end else if (expire_w) begin
        // abandon: no further cycles of this fragment
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end
    end
  end

  assign bus_req_o   = busy_q;
  assign bus_addr_o  = base_q + ADDR_W'(cur_w.aoff);
  assign bus_wdata_o = cur_w.wd;
  assign bus_we_o    = cur_w.we;
  assign bus_byte_o  = cur_w.byt;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/uio_cycle_seq_chk.sv
module uio_cycle_seq_chk #(
  parameter int unsigned ADDR_W  = 22,
  parameter int unsigned TMO_CYC = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              err_o,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [15:0]       bus_wdata_o,
  input logic              bus_we_o,
  input logic              bus_byte_o,
  input logic              bus_ack_i
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] wcnt_q;
  logic [1:0]    acks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      acks_q <= '0;
    end else begin
      if (bus_req_o && !bus_ack_i) wcnt_q <= wcnt_q + 1'b1;
      else                         wcnt_q <= '0;
      if (done_o)                       acks_q <= '0;
      else if (bus_req_o && bus_ack_i)  acks_q <= acks_q + 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && wcnt_q != CW'(TMO_CYC - 1)) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) &&
       $stable(bus_byte_o) && $stable(bus_wdata_o)));  // R6

  AST_TMO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && wcnt_q == CW'(TMO_CYC - 1)) |=>
      (!bus_req_o && done_o && err_o));  // R7

  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);  // R7

  AST_READ_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o) |-> !bus_byte_o);  // R1

  AST_BYTE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_byte_o) |-> (bus_wdata_o[15:8] == 8'h00));  // R3

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);  // R6

  AST_MAX_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i) |-> (acks_q < 2'd2));  // R6
endmodule

bind uio_cycle_seq uio_cycle_seq_chk #(.ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .err_o       (err_o),
  .bus_req_o   (bus_req_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_we_o    (bus_we_o),
  .bus_byte_o  (bus_byte_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/uio_cycle_seq_bench.sv
module uio_cycle_seq_bench;
  localparam int unsigned AW  = 22;
  localparam int unsigned TMO = 16;
  localparam logic [AW-1:0] BASE = 22'h3FF010;

  typedef struct packed {
    logic        wr;
    logic [1:0]  len;
    logic [1:0]  off;
    logic [23:0] wd;
    logic [1:0]  n;
    logic [1:0]  o0;
    logic        b0;
    logic [15:0] d0;
    logic [1:0]  o1;
    logic        b1;
    logic [15:0] d1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 2'd3, 24'h0000A5, 2'd1, 2'd3, 1'b1, 16'h00A5, 2'd0, 1'b0, 16'h0000},
    '{1'b1, 2'd2, 2'd2, 24'h00BEEF, 2'd1, 2'd2, 1'b0, 16'hBEEF, 2'd0, 1'b0, 16'h0000},
    '{1'b1, 2'd2, 2'd1, 24'h001234, 2'd2, 2'd1, 1'b1, 16'h0034, 2'd2, 1'b1, 16'h0012},
    '{1'b1, 2'd3, 2'd1, 24'hABCDEF, 2'd2, 2'd1, 1'b1, 16'h00EF, 2'd2, 1'b0, 16'hABCD},
    '{1'b1, 2'd3, 2'd0, 24'h5A6B7C, 2'd2, 2'd0, 1'b0, 16'h6B7C, 2'd2, 1'b1, 16'h005A},
    '{1'b1, 2'd1, 2'd0, 24'hFFFF11, 2'd1, 2'd0, 1'b1, 16'h0011, 2'd0, 1'b0, 16'h0000},
    '{1'b1, 2'd2, 2'd0, 24'h00C3D2, 2'd1, 2'd0, 1'b0, 16'hC3D2, 2'd0, 1'b0, 16'h0000},
    '{1'b0, 2'd1, 2'd3, 24'h000000, 2'd1, 2'd3, 1'b0, 16'h0000, 2'd0, 1'b0, 16'h0000},
    '{1'b0, 2'd2, 2'd2, 24'h000000, 2'd1, 2'd2, 1'b0, 16'h0000, 2'd0, 1'b0, 16'h0000},
    '{1'b0, 2'd2, 2'd1, 24'h000000, 2'd2, 2'd1, 1'b0, 16'h0000, 2'd3, 1'b0, 16'h0000},
    '{1'b0, 2'd3, 2'd0, 24'h000000, 2'd2, 2'd0, 1'b0, 16'h0000, 2'd2, 1'b0, 16'h0000},
    '{1'b0, 2'd1, 2'd1, 24'h000000, 2'd1, 2'd1, 1'b0, 16'h0000, 2'd0, 1'b0, 16'h0000},
    '{1'b0, 2'd3, 2'd1, 24'h000000, 2'd2, 2'd1, 1'b0, 16'h0000, 2'd3, 1'b0, 16'h0000}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [1:0]    len_i = 2'd1;
  logic          wr_i = 1'b0;
  logic [23:0]   wdata_i = '0;
  logic          done_o, err_o;
  logic [31:0]   rdata_o;
  logic          bus_req_o, bus_we_o, bus_byte_o;
  logic [AW-1:0] bus_addr_o;
  logic [15:0]   bus_wdata_o;
  logic          bus_ack_i = 1'b0;
  logic [15:0]   bus_rdata_i = '0;

  uio_cycle_seq #(.ADDR_W(AW), .TMO_CYC(TMO)) u_uio_cycle_seq (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  // bus responder log
  int            log_n = 0;
  logic [AW-1:0] log_a [64];
  logic          log_we [64];
  logic          log_b [64];
  logic [15:0]   log_d [64];
  int            resp_delay = 0;
  int            resp_left  = 0;

  function automatic logic [15:0] dev_word(input logic [AW-1:0] a);
    return {a[7:0], ~a[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    int wc = 0;
    forever begin
      @(negedge clk_i);
      if (bus_ack_i) begin
        bus_ack_i = 1'b0;
      end else if (!bus_req_o) begin
        wc = 0;
      end else if (resp_left > 0) begin
        if (wc >= resp_delay) begin
          log_a[log_n % 64]  = bus_addr_o;
          log_we[log_n % 64] = bus_we_o;
          log_b[log_n % 64]  = bus_byte_o;
          log_d[log_n % 64]  = bus_wdata_o;
          log_n++;
          bus_rdata_i = dev_word(bus_addr_o);
          bus_ack_i   = 1'b1;
          resp_left--;
          wc = 0;
        end else begin
          wc++;
        end
      end
    end
  end

  task automatic launch(input logic w, input logic [1:0] l, input logic [1:0] o, input logic [23:0] d);
    @(negedge clk_i);
    start_i = 1'b1; wr_i = w; len_i = l; addr_i = BASE + AW'(o); wdata_i = d;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit seen, output logic err, output logic [31:0] rd);
    seen = 1'b0; err = 1'b0; rd = '0;
    for (int k = 0; k < 200 && !seen; k++) begin
      if (done_o) begin
        seen = 1'b1; err = err_o; rd = rdata_o;
      end else begin
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic err;
    logic [31:0] rd;
    int b;

    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!bus_req_o, "R9 req", 32'(bus_req_o), 0);
    chk(!done_o && !err_o, "R9 done/err", {30'd0, done_o, err_o}, 0);
    chk(rdata_o == 0, "R9 rdata", rdata_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      logic [31:0] exp_rd;
      v = VEC[i];
      tg = !v.wr ? "R1" : (v.len == 2'd1) ? "R3" : (v.len == 2'd2) ? "R4" : "R5";
      resp_delay = i % 3;
      resp_left  = 8;
      b = log_n;
      launch(v.wr, v.len, v.off, v.wd);
      wait_done(seen, err, rd);
      chk(seen, "R6 done seen", 32'(seen), 1);
      chk(!err, "R7 no error", 32'(err), 0);
      chk(log_n - b == int'(v.n), {tg, " cycle count"}, 32'(log_n - b), 32'(v.n));
      if (log_n - b >= 1) begin
        chk(log_a[b % 64] == BASE + AW'(v.o0), {tg, " c0 addr"}, 32'(log_a[b % 64]), 32'(BASE + AW'(v.o0)));
        chk(log_we[b % 64] == v.wr && log_b[b % 64] == v.b0, {tg, " c0 type"},
            {30'd0, log_we[b % 64], log_b[b % 64]}, {30'd0, v.wr, v.b0});
        if (v.wr) chk(log_d[b % 64] == v.d0, {tg, " c0 data"}, 32'(log_d[b % 64]), 32'(v.d0));
      end
      if (v.n == 2'd2 && log_n - b >= 2) begin
        chk(log_a[(b + 1) % 64] == BASE + AW'(v.o1), {tg, " c1 addr"}, 32'(log_a[(b + 1) % 64]), 32'(BASE + AW'(v.o1)));
        chk(log_we[(b + 1) % 64] == v.wr && log_b[(b + 1) % 64] == v.b1, {tg, " c1 type"},
            {30'd0, log_we[(b + 1) % 64], log_b[(b + 1) % 64]}, {30'd0, v.wr, v.b1});
        if (v.wr) chk(log_d[(b + 1) % 64] == v.d1, {tg, " c1 data"}, 32'(log_d[(b + 1) % 64]), 32'(v.d1));
      end
      if (!v.wr) begin
        if (v.n == 2'd2)
          exp_rd = {dev_word(BASE + AW'(v.o1)), dev_word(BASE + AW'(v.o0))};
        else if (v.off[1])
          exp_rd = {dev_word(BASE + AW'(v.o0)), 16'h0000};
        else
          exp_rd = {16'h0000, dev_word(BASE + AW'(v.o0))};
        chk(rd == exp_rd, "R2 read placement", rd, exp_rd);
      end
      repeat (3) @(negedge clk_i);
      chk(!bus_req_o && log_n - b == int'(v.n), "R6 no extra cycles", 32'(log_n - b), 32'(v.n));
    end

    // R8: start during a fragment is ignored
    resp_delay = 4; resp_left = 8; b = log_n;
    launch(1'b1, 2'd2, 2'd1, 24'h00A1B2);
    @(negedge clk_i);
    start_i = 1'b1; wr_i = 1'b0; len_i = 2'd1; addr_i = BASE + 22'd8; wdata_i = 24'h777777;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(seen, err, rd);
    repeat (8) @(negedge clk_i);
    chk(log_n - b == 2, "R8 cycle count", 32'(log_n - b), 2);
    chk(log_a[b % 64] == BASE + 22'd1 && log_d[b % 64] == 16'h00B2, "R8 first cycle",
        32'(log_d[b % 64]), 32'h00B2);
    chk(log_a[(b + 1) % 64] == BASE + 22'd2 && log_d[(b + 1) % 64] == 16'h00A1, "R8 second cycle",
        32'(log_d[(b + 1) % 64]), 32'h00A1);
    chk(!bus_req_o, "R8 bus idle", 32'(bus_req_o), 0);

    // R7: no acknowledge at all
    resp_delay = 0; resp_left = 0; b = log_n;
    launch(1'b1, 2'd3, 2'd1, 24'h123456);
    begin
      int cnt = 0;
      while (bus_req_o && cnt < 100) begin
        cnt++;
        @(negedge clk_i);
      end
      chk(cnt == TMO, "R7 request window", 32'(cnt), 32'(TMO));
    end
    chk(done_o && err_o, "R7 abort done/err", {30'd0, done_o, err_o}, 32'h3);
    repeat (4) @(negedge clk_i);
    chk(log_n == b && !bus_req_o, "R7 no cycles issued", 32'(log_n - b), 0);
    chk(err_o, "R7 error held", 32'(err_o), 1);

    // R7: second cycle never acknowledged
    resp_left = 1; b = log_n;
    launch(1'b1, 2'd2, 2'd1, 24'h00DEAD);
    wait_done(seen, err, rd);
    chk(seen && err, "R7 abort on second", {30'd0, seen, err}, 32'h3);
    repeat (4) @(negedge clk_i);
    chk(log_n - b == 1 && !bus_req_o, "R7 stops after first", 32'(log_n - b), 1);

    // R7: next fragment clears error
    resp_left = 8; b = log_n;
    launch(1'b0, 2'd2, 2'd0, 24'h0);
    @(negedge clk_i);
    chk(!err_o, "R7 error cleared on accept", 32'(err_o), 0);
    wait_done(seen, err, rd);
    chk(seen && !err, "R7 clean completion", {30'd0, seen, err}, 32'h2);
    chk(rd == {16'h0000, dev_word(BASE)}, "R2 aligned word", rd, {16'h0000, dev_word(BASE)});

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule